// File: doc/BRIEF.md
# Character Display Write Controller (8-bit parallel)

This block drives a character-cell display module that has an 8-bit parallel bus, a register-select line, a read/write line and an enable strobe. After reset it waits out the display's power-up time. It then issues a fixed series of four setup commands. After that it accepts ASCII bytes from an upstream producer, such as a formatter that turns sensor readings into text, and writes each byte to the display as character data.

Every transfer follows the same pattern: the byte is placed on the bus with the enable low, the enable is raised for a pulse, the bytes are held after the fall, and the block then waits before the next transfer. All of these intervals come from cycle counters whose lengths are parameters. By default they are derived from the clock frequency. The display's busy flag is never read, so the read/write line stays at write.

Top module: `lcd_char_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, `lcd_e`, `lcd_rs`, `char_ready` and all bits of `lcd_db` are 0.
- R2: After reset is released, the first enable pulse rises after POWERUP_CYC + SETUP_CYC clock edges, with the enable low before it.
- R3: The first four transfers are commands (`lcd_rs` = 0), sent in this order: 0x38, 0x0F, 0x06, 0x01. 0x38 is mode set (bit 5) with 8-bit bus (bit 4) and two lines (bit 3). 0x0F is display control (bit 3) with display (bit 2), cursor (bit 1) and blink (bit 0) all on. 0x06 is entry mode (bit 2) with increment (bit 1) and no shift (bit 0). 0x01 is clear.
- R4: Each enable pulse is high for exactly PULSE_CYC clocks. `lcd_db` and `lcd_rs` do not change while the enable is high.
- R5: After any transfer other than clear, the enable stays low for at least HOLD_CYC + SHORT_WAIT_CYC + SETUP_CYC clocks. Between setup commands the low time is exactly that value. When a character is already waiting, the low time is exactly one clock more.
- R6: After the clear command, the enable stays low for at least HOLD_CYC + LONG_WAIT_CYC + SETUP_CYC clocks. When a character is already waiting, the low time is exactly one clock more than that.
- R7: `char_ready` is high only after all four setup commands have been sent, and only while no transfer or wait is in progress. It is never high while `lcd_e` is high.
- R8: A byte is accepted on a clock where `char_valid` and `char_ready` are both high. Accepted bytes appear on `lcd_db` with `lcd_rs` = 1, in the order they were accepted.
- R9: `lcd_rw` is always 0.
- R10: A byte offered on `char_valid` while `char_ready` is low, and withdrawn before `char_ready` rises, is never sent to the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_valid | input | 1 | Producer offers a character byte |
| char_data | input | 8 | ASCII character byte |
| char_ready | output | 1 | Controller can accept a byte on this clock |
| lcd_rs | output | 1 | Register select: 0 for command, 1 for character data |
| lcd_rw | output | 1 | Read/write select, fixed at write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 8 | Display data bus |

## Verification
The bench builds the controller with tiny cycle counts: a 30-clock power-up wait, a 2-clock setup, a 4-clock pulse, a 2-clock hold, and waits of 8 and 20 clocks. With these values, the whole setup sequence, the long wait after clear and several character writes all fit in a few hundred clocks. Every gap can be compared against an exact clock count. A short-lived byte offered during the power-up wait covers the ignore case. A reset asserted in the middle of a pulse shows that the pins return to their reset state.

// File: rtl/lcd_pkg.sv
`timescale 1ns/1ps
package lcd_pkg;

  // setup command bytes, built from their field bits
  localparam logic [7:0] CMD_MODE  = 8'h20 | 8'h10 | 8'h08;        // 8-bit bus, two lines, 5x8 font
  localparam logic [7:0] CMD_SHOW  = 8'h08 | 8'h04 | 8'h02 | 8'h01; // display, cursor, blink on
  localparam logic [7:0] CMD_ENTRY = 8'h04 | 8'h02;                 // increment, no shift
  localparam logic [7:0] CMD_CLEAR = 8'h01;

  typedef enum logic [2:0] {
    WAIT_SETUP, WAIT_PULSE, WAIT_HOLD, WAIT_SHORT, WAIT_LONG
  } waitSel_e;

  typedef struct packed {
    logic     loadCmd;
    logic     loadChar;
    logic     eHigh;
    logic     eLow;
    logic     cntLoad;
    waitSel_e cntSel;
  } lcdStrobe_t;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_SETUP, ST_PULSE, ST_HOLD, ST_GAP, ST_IDLE
  } ctrlState_e;

  function automatic logic [7:0] initByte(input logic [1:0] idx);
    case (idx)
      2'd0:    return CMD_MODE;
      2'd1:    return CMD_SHOW;
      2'd2:    return CMD_ENTRY;
      default: return CMD_CLEAR;
    endcase
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_datapath.sv
`timescale 1ns/1ps
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int POWERUP_CYC    = 30,
  parameter int SETUP_CYC      = 2,
  parameter int PULSE_CYC      = 4,
  parameter int HOLD_CYC       = 2,
  parameter int SHORT_WAIT_CYC = 8,
  parameter int LONG_WAIT_CYC  = 20,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lcdStrobe_t        strobe,
  input  logic [1:0]        cmdIdx,
  input  logic [DATA_W-1:0] charData,
  output logic              cntDone,
  output logic              lcdRs,
  output logic              lcdE,
  output logic [DATA_W-1:0] lcdDb
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(POWERUP_CYC, SETUP_CYC), maxOf(PULSE_CYC, HOLD_CYC)),
                                 maxOf(SHORT_WAIT_CYC, LONG_WAIT_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (strobe.cntSel)
      WAIT_SETUP: loadVal = CNT_W'(SETUP_CYC - 1);
      WAIT_PULSE: loadVal = CNT_W'(PULSE_CYC - 1);
      WAIT_HOLD:  loadVal = CNT_W'(HOLD_CYC - 1);
      WAIT_SHORT: loadVal = CNT_W'(SHORT_WAIT_CYC - 1);
      default:    loadVal = CNT_W'(LONG_WAIT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= CNT_W'(POWERUP_CYC - 1);
    else if (strobe.cntLoad) cnt <= loadVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcdRs <= 1'b0;
      lcdE  <= 1'b0;
      lcdDb <= '0;
    end else begin
      if (strobe.loadCmd) begin
        lcdRs <= 1'b0;
        lcdDb <= DATA_W'(initByte(cmdIdx));
      end else if (strobe.loadChar) begin
        lcdRs <= 1'b1;
        lcdDb <= charData;
      end
      if (strobe.eHigh)     lcdE <= 1'b1;
      else if (strobe.eLow) lcdE <= 1'b0;
    end
  end

  // R4
  db_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lcdE && $past(lcdE)) |-> ($stable(lcdDb) && $stable(lcdRs)));

  // R4
  no_load_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    lcdE |-> !(strobe.loadCmd || strobe.loadChar));

endmodule

// File: rtl/lcd_ctrl.sv
`timescale 1ns/1ps
module lcd_ctrl
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cntDone,
  input  logic       charValid,
  output logic       charReady,
  output logic [1:0] cmdIdx,
  output lcdStrobe_t strobe
);

  localparam logic [1:0] LAST_CMD = 2'd3;

  ctrlState_e state, stateNxt;
  logic [1:0] step;
  logic       initDone;
  logic       isClear;

  assign isClear   = !initDone && (step == LAST_CMD);
  assign charReady = (state == ST_IDLE);
  assign cmdIdx    = (state == ST_GAP) ? step + 2'd1 : step;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_PWRUP: if (cntDone) begin
        strobe.loadCmd = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = WAIT_SETUP;
        stateNxt       = ST_SETUP;
      end
      ST_SETUP: if (cntDone) begin
        strobe.eHigh   = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = WAIT_PULSE;
        stateNxt       = ST_PULSE;
      end
      ST_PULSE: if (cntDone) begin
        strobe.eLow    = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = WAIT_HOLD;
        stateNxt       = ST_HOLD;
      end
      ST_HOLD: if (cntDone) begin
        strobe.cntLoad = 1'b1;
        strobe.cntSel  = isClear ? WAIT_LONG : WAIT_SHORT;
        stateNxt       = ST_GAP;
      end
      ST_GAP: if (cntDone) begin
        if (initDone || step == LAST_CMD) begin
          stateNxt = ST_IDLE;
        end else begin
          strobe.loadCmd = 1'b1;
          strobe.cntLoad = 1'b1;
          strobe.cntSel  = WAIT_SETUP;
          stateNxt       = ST_SETUP;
        end
      end
      ST_IDLE: if (charValid) begin
        strobe.loadChar = 1'b1;
        strobe.cntLoad  = 1'b1;
        strobe.cntSel   = WAIT_SETUP;
        stateNxt        = ST_SETUP;
      end
      default: stateNxt = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWRUP;
      step     <= '0;
      initDone <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_GAP && cntDone && !initDone) begin
        if (step == LAST_CMD) initDone <= 1'b1;
        else                  step     <= step + 2'd1;
      end
    end
  end

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    charReady |-> initDone);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe.eHigh && strobe.eLow) && !(strobe.loadCmd && strobe.loadChar));

  // R3
  no_char_in_init_chk: assert property (@(posedge clk) disable iff (rst)
    !initDone |-> !strobe.loadChar);

endmodule

// File: rtl/lcd_char_ctrl.sv
`timescale 1ns/1ps
module lcd_char_ctrl
  import lcd_pkg::*;
#(
  parameter int CLK_MHZ        = 50,
  parameter int POWERUP_CYC    = 15000 * CLK_MHZ + 1,
  parameter int SETUP_CYC      = CLK_MHZ / 20 + 1,
  parameter int PULSE_CYC      = (450 * CLK_MHZ) / 1000 + 1,
  parameter int HOLD_CYC       = CLK_MHZ / 50 + 1,
  parameter int SHORT_WAIT_CYC = 40 * CLK_MHZ + 1,
  parameter int LONG_WAIT_CYC  = 1640 * CLK_MHZ + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       char_valid,
  input  logic [7:0] char_data,
  output logic       char_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);

  localparam int DATA_W = 8;

  lcdStrobe_t strobe;
  logic [1:0] cmdIdx;
  logic       cntDone;

  lcd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cntDone   (cntDone),
    .charValid (char_valid),
    .charReady (char_ready),
    .cmdIdx    (cmdIdx),
    .strobe    (strobe)
  );

  lcd_datapath #(
    .POWERUP_CYC    (POWERUP_CYC),
    .SETUP_CYC      (SETUP_CYC),
    .PULSE_CYC      (PULSE_CYC),
    .HOLD_CYC       (HOLD_CYC),
    .SHORT_WAIT_CYC (SHORT_WAIT_CYC),
    .LONG_WAIT_CYC  (LONG_WAIT_CYC),
    .DATA_W         (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cmdIdx   (cmdIdx),
    .charData (char_data),
    .cntDone  (cntDone),
    .lcdRs    (lcd_rs),
    .lcdE     (lcd_e),
    .lcdDb    (lcd_db)
  );

  assign lcd_rw = 1'b0;

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_ready) |=> (lcd_rs && lcd_db == $past(char_data)));

  // R7
  ready_e_chk: assert property (@(posedge clk) disable iff (rst)
    char_ready |-> !lcd_e);

endmodule

// File: tb/sim_lcd_char_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_char_ctrl;

  localparam int PWR = 30, SU = 2, PW = 4, HD = 2, SH = 8, LG = 20;
  localparam int NX  = 8;

  // {rs, byte} expected per transfer; entries 4..7 are also the stimulus stream
  localparam logic [8:0] EXP_XFER [NX] = '{9'h038, 9'h00F, 9'h006, 9'h001,
                                           9'h154, 9'h13D, 9'h132, 9'h135};
  localparam int EXP_LOW [NX] = '{PWR+SU-1, HD+SH+SU, HD+SH+SU, HD+SH+SU,
                                  HD+LG+1+SU, HD+SH+1+SU, HD+SH+1+SU, HD+SH+1+SU};

  logic clk = 0, rst = 1;
  logic charValid = 0;
  logic [7:0] charData = 0;
  logic charReady, lcdRs, lcdRw, lcdE;
  logic [7:0] lcdDb;

  int checks = 0, errors = 0;
  bit monOn = 0, done = 0;
  int xferCnt = 0, lowCnt = 0, highCnt = 0;
  int stableErr = 0, readyErr = 0, rwErr = 0, junkSeen = 0;
  logic prevE = 0;
  logic capRs;
  logic [7:0] capDb;

  always #2.5 clk = ~clk;

  lcd_char_ctrl #(
    .POWERUP_CYC(PWR), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
    .SHORT_WAIT_CYC(SH), .LONG_WAIT_CYC(LG)
  ) u0 (
    .clk(clk), .rst(rst), .char_valid(charValid), .char_data(charData),
    .char_ready(charReady), .lcd_rs(lcdRs), .lcd_rw(lcdRw), .lcd_e(lcdE), .lcd_db(lcdDb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampling on the falling clock edge
  always @(negedge clk) if (monOn) begin
    if (lcdRw !== 1'b0) rwErr++;
    if (charReady && (xferCnt < 4 || lcdE)) readyErr++;
    if (lcdE) begin
      if (!prevE) begin
        capRs = lcdRs; capDb = lcdDb; highCnt = 1;
        if (capDb == 8'hAA) junkSeen++;
        if (xferCnt < NX) begin
          check({capRs, capDb} == EXP_XFER[xferCnt], (xferCnt < 4) ? "R3" : "R8",
                {capRs, capDb}, EXP_XFER[xferCnt]);
          if (xferCnt == 4) check(lowCnt == EXP_LOW[xferCnt], "R6", lowCnt, EXP_LOW[xferCnt]);
          else if (xferCnt == 0) check(lowCnt == EXP_LOW[xferCnt], "R2", lowCnt, EXP_LOW[xferCnt]);
          else check(lowCnt == EXP_LOW[xferCnt], "R5", lowCnt, EXP_LOW[xferCnt]);
        end
      end else begin
        highCnt++;
        if (lcdDb !== capDb || lcdRs !== capRs) stableErr++;
      end
    end else begin
      if (prevE) begin
        check(highCnt == PW, "R4", highCnt, PW);
        xferCnt++;
        lowCnt = 1;
      end else lowCnt++;
    end
    prevE = lcdE;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lcdE == 0 && lcdRs == 0 && charReady == 0, "R1", {lcdE, lcdRs, charReady}, 0);
    check(lcdDb == 8'h00, "R1", lcdDb, 0);
    #1 rst = 0; monOn = 1;
    // R10: short-lived offer during power-up wait
    repeat (3) @(negedge clk);
    charValid = 1; charData = 8'hAA;
    repeat (5) @(negedge clk);
    check(charReady == 0, "R10", charReady, 0);
    charValid = 0; charData = 8'h00;
    repeat (20) @(negedge clk);
    // stream walked from the vector table
    for (int i = 4; i < NX; i++) begin
      charValid = 1; charData = EXP_XFER[i][7:0];
      while (!charReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    charValid = 0;
    repeat (60) @(negedge clk);
    check(xferCnt == NX, "R8", xferCnt, NX);
    check(stableErr == 0, "R4", stableErr, 0);
    check(readyErr == 0, "R7", readyErr, 0);
    check(rwErr == 0, "R9", rwErr, 0);
    check(junkSeen == 0, "R10", junkSeen, 0);
    check(charReady == 1, "R7", charReady, 1);
    // reset in the middle of a pulse
    charValid = 1; charData = 8'h5A;
    while (!lcdE) @(negedge clk);
    monOn = 0; charValid = 0;
    #1 rst = 1;
    @(negedge clk);
    check(lcdE == 0 && lcdRs == 0 && charReady == 0, "R1", {lcdE, lcdRs, charReady}, 0);
    check(lcdDb == 8'h00, "R1", lcdDb, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule